// File: doc/BRIEF.md
# Next Program Counter Unit

This unit owns the program counter of a single-cycle 32-bit RISC core. It looks at the instruction fetched in the current cycle and picks the next fetch address. There are four kinds of next address:

- the plain sequential successor;
- a PC-relative conditional branch target;
- a pseudo-direct jump target, built from a 26-bit word index and the upper address bits;
- a register-indirect target, taken from an operand value.

The register file, ALU and data memory sit outside the unit. The core feeds in the two values compared by a branch and the value that an indirect jump uses. The unit also drives the return-link address at all times. The register file writes that address when a jump-and-link retires.

The PC is updated once per clock edge. A synchronous reset sets it to the start of the text segment. The next-address choice is combinational on the current PC and the instruction, so a new target takes effect at the following edge with no delay slot.

Top module: `npc_unit`

## Requirements
- R1: With `rst` high at a rising edge, `pc_o` becomes 0x00400000 at that edge.
- R2: Any opcode (instr[31:26]) other than 2, 3, 4 and 5 advances `pc_o` by 4 at the next edge. This includes opcode 0 when the function field instr[5:0] is not 8.
- R3: Opcode 4 loads `pc_o` + 4 + 4×sign_extend(instr[15:0]) when `cmp_a` equals `cmp_b`. Otherwise it loads `pc_o` + 4.
- R4: Opcode 5 takes the same target as R3 when `cmp_a` differs from `cmp_b`. Otherwise it loads `pc_o` + 4.
- R5: The branch offset is a signed 16-bit word count. 0x7FFF reaches +131068 bytes from `pc_o` + 4, and 0x8000 reaches −131072 bytes.
- R6: Opcodes 2 and 3 load {(`pc_o`+4)[31:28], instr[25:0], 2'b00}.
- R7: For the jumps of R6, the upper four bits come from `pc_o` + 4. A jump in the last word of a 256 MB region therefore lands in the next region.
- R8: Opcode 0 with function field instr[5:0] = 8 loads `pc_o` from `jreg_val`.
- R9: `link_o` always equals `pc_o` + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction fetched at `pc_o` |
| cmp_a | input | 32 | First branch comparison operand |
| cmp_b | input | 32 | Second branch comparison operand |
| jreg_val | input | 32 | Target value for register-indirect jumps |
| pc_o | output | 32 | Current program counter |
| link_o | output | 32 | Return-link address (`pc_o` + 4) |

## Verification
The only state in the unit is the PC itself. A wrong selection or a bad target field shows up on `pc_o` one edge after the instruction that caused it, and from then on every later address is offset by the error. Because `link_o` is derived from the same register, it goes wrong in the same cycle. The checks therefore compare the PC after every single instruction and do not only look at the end of a sequence. Sign-extension faults show up only on the negative and extreme offsets. Region-bit faults show up only when a jump sits at a 256 MB boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN     = 32;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int REGION_W = XLEN - JIDX_W - 2;
  localparam int SEXT_W   = XLEN - IMM_W - 2;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OPC_J     = 6'd2;
  localparam logic [OP_W-1:0] OPC_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [FN_W-1:0] FN_JR     = 6'd8;

  typedef enum logic [1:0] {
    NXT_SEQ      = 2'd0,
    NXT_BRANCH   = 2'd1,
    NXT_PSEUDO   = 2'd2,
    NXT_INDIRECT = 2'd3
  } nxt_sel_e;

  function automatic logic [XLEN-1:0] seq_addr(input logic [XLEN-1:0] pc);
    return pc + XLEN'(4);
  endfunction

  function automatic logic [XLEN-1:0] br_addr(input logic [XLEN-1:0] pc4,
                                              input logic [IMM_W-1:0] imm);
    return pc4 + {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jmp_addr(input logic [XLEN-1:0] pc4,
                                               input logic [JIDX_W-1:0] idx);
    return {pc4[XLEN-1 -: REGION_W], idx, 2'b00};
  endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output nxt_sel_e        sel,
  output logic            br_taken
);
  logic [OP_W-1:0] opc;
  logic [FN_W-1:0] funct;
  logic            ops_equal;

  assign opc       = instr[XLEN-1 -: OP_W];
  assign funct     = instr[FN_W-1:0];
  assign ops_equal = (cmp_a == cmp_b);

  always_comb begin
    br_taken = 1'b0;
    sel      = NXT_SEQ;
    case (opc)
      OPC_BEQ: br_taken = ops_equal;
      OPC_BNE: br_taken = !ops_equal;
      OPC_J, OPC_JAL: sel = NXT_PSEUDO;
      OPC_RTYPE: if (funct == FN_JR) sel = NXT_INDIRECT;
      default: sel = NXT_SEQ;
    endcase
    if (br_taken) sel = NXT_BRANCH;
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] seq_tgt,
  output logic [XLEN-1:0] br_tgt,
  output logic [XLEN-1:0] jmp_tgt
);
  assign seq_tgt = seq_addr(pc);
  assign br_tgt  = br_addr(seq_tgt, instr[IMM_W-1:0]);
  assign jmp_tgt = jmp_addr(seq_tgt, instr[JIDX_W-1:0]);
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  nxt_sel_e        sel,
  input  logic [XLEN-1:0] seq_tgt,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] next_pc
);
  always_comb begin
    case (sel)
      NXT_BRANCH:   next_pc = br_tgt;
      NXT_PSEUDO:   next_pc = jmp_tgt;
      NXT_INDIRECT: next_pc = reg_tgt;
      default:      next_pc = seq_tgt;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] instr,
  input  logic [31:0] cmp_a,
  input  logic [31:0] cmp_b,
  input  logic [31:0] jreg_val,
  output logic [31:0] pc_o,
  output logic [31:0] link_o
);
  nxt_sel_e        sel_w;
  logic            br_taken_w;
  logic [XLEN-1:0] seq_w, br_w, jmp_w, next_w;
  logic [XLEN-1:0] pc_q;

  npc_decode u_dec (
    .instr(instr), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .sel(sel_w), .br_taken(br_taken_w)
  );

  npc_targets u_tgt (
    .pc(pc_q), .instr(instr),
    .seq_tgt(seq_w), .br_tgt(br_w), .jmp_tgt(jmp_w)
  );

  npc_select u_sel (
    .sel(sel_w), .seq_tgt(seq_w), .br_tgt(br_w), .jmp_tgt(jmp_w),
    .reg_tgt(jreg_val), .next_pc(next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VEC;
    else     pc_q <= next_w;
  end

  assign pc_o   = pc_q;
  assign link_o = seq_w;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] cmp_a,
  input logic [31:0] cmp_b,
  input logic [31:0] jreg_val,
  input logic [31:0] pc_o,
  input logic [31:0] link_o,
  input nxt_sel_e    sel_w
);
  logic        prev_rst;
  logic [31:0] ofs;
  logic [5:0]  opc;

  always_ff @(posedge clk) prev_rst <= rst;
  assign opc = instr[31:26];
  assign ofs = {{14{instr[15]}}, instr[15:0], 2'b00};

  p_reset_vec_r1: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> pc_o == RESET_VEC);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sel_w == NXT_SEQ) |=> pc_o == $past(pc_o) + 32'd4);

  p_beq_taken_r3: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd4 && cmp_a == cmp_b) |=> pc_o == $past(pc_o) + 32'd4 + $past(ofs));

  p_bne_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd5 && cmp_a != cmp_b) |=> pc_o == $past(pc_o) + 32'd4 + $past(ofs));

  p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd2 || opc == 6'd3) |=>
      (pc_o[31:28] == $past(link_o[31:28]) && pc_o[27:0] == {$past(instr[25:0]), 2'b00}));

  p_indirect_r8: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd0 && instr[5:0] == 6'd8) |=> pc_o == $past(jreg_val));
endmodule

bind npc_unit npc_unit_chk #(.RESET_VEC(RESET_VEC)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .cmp_a(cmp_a), .cmp_b(cmp_b),
  .jreg_val(jreg_val), .pc_o(pc_o), .link_o(link_o), .sel_w(sel_w)
);

// File: tb/npc_unit_test.sv
module npc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'd0, cmp_a = 32'd0, cmp_b = 32'd0, jreg_val = 32'd0;
  logic [31:0] pc_o, link_o;

  localparam logic [31:0] BOOT = 32'h0040_0000;

  npc_unit uut (
    .clk(clk), .rst(rst), .instr(instr), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .jreg_val(jreg_val), .pc_o(pc_o), .link_o(link_o)
  );

  always #5 clk = ~clk;

  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] mpc;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] model_next(input logic [31:0] pc, input logic [31:0] ins,
                                             input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] r);
    logic signed [31:0] woff;
    logic [31:0] after;
    after = pc + 32'd4;
    woff  = 32'($signed(ins[15:0]));
    case (ins[31:26])
      6'd4: return (a == b) ? after + 32'(woff * 4) : after;
      6'd5: return (a != b) ? after + 32'(woff * 4) : after;
      6'd2, 6'd3: return (after & 32'hF000_0000) | (32'(ins[25:0]) << 2);
      6'd0: return (ins[5:0] == 6'd8) ? r : after;
      default: return after;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // driver: applies one instruction and queues the expected PC
  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] r, input string req);
    @(negedge clk);
    rst = 1'b0; instr = ins; cmp_a = a; cmp_b = b; jreg_val = r;
    #1 check("R9 link", link_o, mpc + 32'd4);
    mpc = model_next(mpc, ins, a, b, r);
    exp_q.push_back(mpc);
    tag_q.push_back(req);
  endtask

  // monitor: compares the PC after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) check(tag_q.pop_front(), pc_o, exp_q.pop_front());
  end

  function automatic logic [31:0] i_fmt(input int op, input logic [15:0] imm);
    return {6'(op), 5'd8, 5'd9, imm};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_o, BOOT);
    check("R9 reset link", link_o, BOOT + 32'd4);
    mpc = BOOT;
    step(32'h0128_4020, 0, 0, 0, "R2 add");
    step(i_fmt(8, 16'h0005), 0, 0, 0, "R2 addi");
    step(i_fmt(4, 16'h0002), 7, 7, 0, "R3 beq taken +2");
    step(i_fmt(4, 16'h0002), 7, 6, 0, "R3 beq not taken");
    step(i_fmt(5, 16'hFFF8), 1, 2, 0, "R4 R5 bne taken -8");
    step(i_fmt(5, 16'hFFF8), 3, 3, 0, "R4 bne not taken");
    step(i_fmt(4, 16'hFFF8), 9, 9, 0, "R3 R5 beq taken -8");
    step({6'd2, 26'h010_0008}, 0, 0, 0, "R6 j");
    step({6'd3, 26'h010_0040}, 0, 0, 0, "R6 jal");
    step({6'd0, 5'd31, 15'd0, 6'd8}, 0, 0, 32'h0FFF_FFFC, "R8 jr");
    step({6'd2, 26'h000_0010}, 0, 0, 0, "R7 region cross");
    step(i_fmt(4, 16'h7FFF), 4, 4, 0, "R5 max forward");
    step(i_fmt(4, 16'h8000), 4, 4, 0, "R5 max backward");
    step({6'd0, 5'd31, 15'd0, 6'd9}, 0, 0, 32'h1234_5678, "R2 op0 funct9");
    step({6'd1, 26'h3FF_FFFF}, 1, 1, 0, "R2 opcode1");
    @(negedge clk);
    rst = 1'b1;
    mpc = BOOT;
    exp_q.push_back(BOOT);
    tag_q.push_back("R1 mid-run reset");
    @(negedge clk);
    step(i_fmt(5, 16'h0001), 1, 0, 0, "R4 after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule